// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Datapath

This block is a complete 32-bit single-cycle datapath. In every clock period it takes the instruction that sits at the current program counter and reads two source registers. It then forms the second ALU operand and computes an ALU result. Depending on the instruction, it either touches data memory or writes a value back into the register file. The next-PC choice is made in the same cycle. It can be PC+4, a PC-relative branch target or a region-relative jump target, and it follows the branch and jump flags that the ALU raises.

Instruction storage is a word-addressed ROM whose contents are given as a parameter. Data storage is a word-wide RAM with separate read and write strobes. Every access moves a full word. The instruction register is loaded from the next-PC address on each edge. As a result, the instruction on `instr_o` always belongs to the PC on `pc_o`.

The ports bring out the program counter, the instruction, the write-back request and the data-memory request. An integrator or a bench can follow execution instruction by instruction through them.

Top module: `scdp_core`

## Requirements
- R1: While `rst` is high, on each rising edge the PC becomes 0, the instruction becomes ROM word 0, and all registers and data words clear to zero. An instruction executed right after reset that reads registers sees zeros.
- R2: When neither branch nor jump is taken, the PC advances by 4 each cycle, and `instr_o` holds the ROM word at `pc_o[6:2]`.
- R3: Opcode 0x00 with function field (bits 5:0) 0x20 add, 0x22 sub, 0x24 and, 0x25 or or 0x2A signed set-less-than reads registers from bits 25:21 and 20:16. It writes the result to the register named by bits 15:11.
- R4: Opcode 0x08 adds register[25:21] to the sign-extended 16-bit immediate and writes the sum to the register named by bits 20:16.
- R5: Opcode 0x23 asserts `dm_re_o` with address register[25:21] + sign-extended immediate. It writes the word read from memory to register[20:16].
- R6: Opcode 0x2B asserts `dm_we_o` with the same address form and register[20:16] as write data. It makes no register write.
- R7: Opcode 0x04 compares register[25:21] with register[20:16]. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2; otherwise it is PC+4. It makes no register write.
- R8: Opcode 0x02 sets the next PC to bits 31:28 of PC+4 joined with instruction bits 25:0 and two zero bits.
- R9: Register 0 always reads as zero, and a write aimed at it leaves it zero.
- R10: Any other opcode, or opcode 0x00 with an unlisted function field, makes no register write and no memory access, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction being executed |
| rf_we_o | output | 1 | Register write request this cycle |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Write-back value |
| dm_re_o | output | 1 | Data memory read strobe |
| dm_we_o | output | 1 | Data memory write strobe |
| dm_addr_o | output | 32 | Data memory byte address (ALU result) |
| dm_wdata_o | output | 32 | Data memory write value |
| dm_rdata_o | output | 32 | Data memory read value (zero when not reading) |

## Verification
A fixed program runs twice, separated by a reset, and covers a wide range of encodings.

- Each arithmetic function uses a positive and a negative operand, so add, sub, and, or and signed compare each give a result the others cannot.
- A negative immediate separates sign extension from zero extension.
- The store/load pair shows that the address, the write data and the write-back selection line up.
- A taken branch, an untaken branch, a backward self-loop branch and a jump each leave a different next PC.
- An undefined opcode shows the absence of side effects.
- The first instruction after the second reset reads registers that the first pass had filled, which tells a real clear apart from stale state.

// File: rtl/scdp_pkg.sv
package scdp_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  // ALU function codes; arithmetic codes equal the R-type function field
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;
  localparam logic [5:0] FN_CMP = 6'h3E;  // equality compare, raises branch
  localparam logic [5:0] FN_JMP = 6'h3F;  // raises jump

  typedef struct packed {
    logic       reg_dst;
    logic       alu_src;
    logic       reg_write;
    logic       mem_read;
    logic       mem_write;
    logic       mem_to_reg;
    logic [5:0] alu_fn;
  } ctrl_t;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] branch_dest(input logic [31:0] pc4, input logic [15:0] off);
    return pc4 + (sext16(off) << 2);
  endfunction

  function automatic logic [31:0] jump_dest(input logic [31:0] pc4, input logic [25:0] tgt);
    return {pc4[31:28], tgt, 2'b00};
  endfunction

endpackage

// File: rtl/scdp_alu.sv
module scdp_alu
  import scdp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [5:0]   fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         br,
  output logic         jmp
);

  always_comb begin
    y   = '0;
    br  = 1'b0;
    jmp = 1'b0;
    case (fn)
      FN_ADD: y = a + b;
      FN_SUB: y = a - b;
      FN_AND: y = a & b;
      FN_OR:  y = a | b;
      FN_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      FN_CMP: begin
        y  = a - b;
        br = (a == b);
      end
      FN_JMP: jmp = 1'b1;
      default: y = '0;
    endcase
  end

  // R7/R8: the two PC redirects never compete
  always_comb begin
    assert_branch_jump_excl_R8: assert (!(br && jmp));
  end

endmodule

// File: rtl/scdp_decode.sv
module scdp_decode
  import scdp_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_fn = FN_ADD;
    case (opcode)
      OP_RTYPE: begin
        case (funct)
          FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT: begin
            ctrl.reg_dst   = 1'b1;
            ctrl.reg_write = 1'b1;
            ctrl.alu_fn    = funct;
          end
          default: ;
        endcase
      end
      OP_ADDI: begin
        ctrl.alu_src   = 1'b1;
        ctrl.reg_write = 1'b1;
      end
      OP_LOAD: begin
        ctrl.alu_src    = 1'b1;
        ctrl.reg_write  = 1'b1;
        ctrl.mem_read   = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OP_STORE: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ:  ctrl.alu_fn = FN_CMP;
      OP_JUMP: ctrl.alu_fn = FN_JMP;
      default: ;
    endcase
  end

  always_comb begin
    assert_store_no_wb_R6: assert (!(ctrl.mem_write && ctrl.reg_write));
    assert_mem_strobe_excl_R5: assert (!(ctrl.mem_read && ctrl.mem_write));
  end

endmodule

// File: rtl/scdp_regfile.sv
module scdp_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

  assert_zero_reg_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (we && (waddr == '0)) |=> (regs[0] == '0));

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (regs[NREG-1] == '0));

endmodule

// File: rtl/scdp_core.sv
module scdp_core
  import scdp_pkg::*;
#(
  parameter int W          = 32,
  parameter int IMEM_WORDS = 32,
  parameter int DMEM_WORDS = 32,
  parameter logic [IMEM_WORDS*W-1:0] PROGRAM = '0,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic         clk,
  input  logic         rst,
  output logic [31:0]  pc_o,
  output logic [31:0]  instr_o,
  output logic         rf_we_o,
  output logic [4:0]   rf_waddr_o,
  output logic [31:0]  rf_wdata_o,
  output logic         dm_re_o,
  output logic         dm_we_o,
  output logic [31:0]  dm_addr_o,
  output logic [31:0]  dm_wdata_o,
  output logic [31:0]  dm_rdata_o
);

  logic [W-1:0]   pc, pc4, pc_next, instr;
  logic [IAW-1:0] fetch_idx;
  ctrl_t          ctrl;
  logic [4:0]     waddr;
  logic [W-1:0]   ra, rb, imm_x, alu_b, alu_y, rdata, wb;
  logic           br, jmp;
  logic [DAW-1:0] dm_idx;
  logic [W-1:0]   dmem [DMEM_WORDS];

  // Fetch: the instruction register is loaded from the next-PC address
  assign fetch_idx = pc_next[IAW+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      instr <= PROGRAM[W-1:0];
    end else begin
      pc    <= pc_next;
      instr <= PROGRAM[fetch_idx*W +: W];
    end
  end

  scdp_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  assign waddr = ctrl.reg_dst ? instr[15:11] : instr[20:16];
  assign imm_x = sext16(instr[15:0]);

  scdp_regfile #(.W(W), .NREG(32)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (ctrl.reg_write),
    .waddr   (waddr),
    .wdata   (wb),
    .raddr_a (instr[25:21]),
    .raddr_b (instr[20:16]),
    .rdata_a (ra),
    .rdata_b (rb)
  );

  assign alu_b = ctrl.alu_src ? imm_x : rb;

  scdp_alu #(.W(W)) u_alu (
    .fn  (ctrl.alu_fn),
    .a   (ra),
    .b   (alu_b),
    .y   (alu_y),
    .br  (br),
    .jmp (jmp)
  );

  // Word-wide data RAM, full-word accesses only
  assign dm_idx = alu_y[DAW+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
    end else if (ctrl.mem_write) begin
      dmem[dm_idx] <= rb;
    end
  end

  assign rdata = ctrl.mem_read ? dmem[dm_idx] : '0;
  assign wb    = ctrl.mem_to_reg ? rdata : alu_y;

  // Next PC
  assign pc4     = pc + 32'd4;
  assign pc_next = jmp ? jump_dest(pc4, instr[25:0]) :
                   br  ? branch_dest(pc4, instr[15:0]) : pc4;

  assign pc_o       = pc;
  assign instr_o    = instr;
  assign rf_we_o    = ctrl.reg_write;
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wb;
  assign dm_re_o    = ctrl.mem_read;
  assign dm_we_o    = ctrl.mem_write;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rb;
  assign dm_rdata_o = rdata;

  assert_reset_pc_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == '0));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!br && !jmp) |=> (pc == $past(pc) + 32'd4));

  assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
    (br && !jmp) |=> (pc == $past(pc) + 32'd4 + ($past(imm_x) << 2)));

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
    jmp |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));

endmodule

// File: tb/tb_scdp_core.sv
`timescale 1ns/100ps
module tb_scdp_core;

  localparam int IMW = 32;

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'h00, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] enc_j(input int tgt);
    return {6'h02, tgt[25:0]};
  endfunction

  function automatic logic [IMW*32-1:0] build_prog();
    logic [IMW*32-1:0] p;
    p = '0;
    p[32*0  +: 32] = enc_r(3, 7, 12, 6'h20);   // R1: reads cleared regs
    p[32*1  +: 32] = enc_i(6'h08, 0, 1, 5);    // R4
    p[32*2  +: 32] = enc_i(6'h08, 0, 2, -3);   // R4 negative immediate
    p[32*3  +: 32] = enc_r(1, 2, 3, 6'h20);    // R3 add
    p[32*4  +: 32] = enc_r(1, 2, 4, 6'h22);    // R3 sub
    p[32*5  +: 32] = enc_r(1, 2, 5, 6'h24);    // R3 and
    p[32*6  +: 32] = enc_r(1, 2, 6, 6'h25);    // R3 or
    p[32*7  +: 32] = enc_r(2, 1, 7, 6'h2A);    // R3 slt
    p[32*8  +: 32] = enc_i(6'h08, 0, 0, 7);    // R9 write to r0
    p[32*9  +: 32] = enc_i(6'h2B, 0, 4, 8);    // R6
    p[32*10 +: 32] = enc_i(6'h2B, 0, 1, 4);    // R6
    p[32*11 +: 32] = enc_i(6'h23, 0, 8, 8);    // R5
    p[32*12 +: 32] = enc_r(0, 8, 9, 6'h20);    // R9 read of r0
    p[32*13 +: 32] = enc_i(6'h04, 8, 4, 2);    // R7 taken
    p[32*14 +: 32] = enc_i(6'h08, 0, 10, 1);
    p[32*15 +: 32] = enc_i(6'h08, 0, 10, 2);
    p[32*16 +: 32] = enc_i(6'h04, 1, 2, 5);    // R7 not taken
    p[32*17 +: 32] = enc_i(6'h3F, 1, 13, 9);   // R10
    p[32*18 +: 32] = enc_j(21);                // R8
    p[32*19 +: 32] = enc_i(6'h08, 0, 11, 1);
    p[32*20 +: 32] = enc_i(6'h08, 0, 11, 2);
    p[32*21 +: 32] = enc_i(6'h04, 0, 0, -1);   // R7 backward self-loop
    return p;
  endfunction

  localparam logic [IMW*32-1:0] PROG = build_prog();

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o, dm_rdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_re_o, dm_we_o;

  always #2.5 clk = ~clk;

  scdp_core #(.IMEM_WORDS(IMW), .DMEM_WORDS(32), .PROGRAM(PROG)) dut (
    .clk(clk), .rst(rst), .pc_o(pc_o), .instr_o(instr_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_re_o(dm_re_o), .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o),
    .dm_wdata_o(dm_wdata_o), .dm_rdata_o(dm_rdata_o)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic        rf_we;
    logic [4:0]  waddr;
    logic [31:0] wdata;
    logic        dm_re;
    logic        dm_we;
    logic [31:0] daddr;
    logic [31:0] dwdata;
    int          tag;
    int          pctag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  task automatic chk(input int tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: architectural model from the requirements, pushes one item per cycle
  task automatic push_run(input int n);
    logic [31:0] r [32];
    logic [31:0] m [32];
    logic [31:0] pc;
    int          pctag;
    for (int i = 0; i < 32; i++) begin r[i] = '0; m[i] = '0; end
    pc = '0;
    pctag = 1;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      logic [31:0] ins, a, b, imm, nx;
      ins = PROG[pc[6:2]*32 +: 32];
      e = '0;
      e.pc = pc;
      e.pctag = pctag;
      a = r[ins[25:21]];
      b = r[ins[20:16]];
      imm = {{16{ins[15]}}, ins[15:0]};
      nx = pc + 32'd4;
      pctag = 2;                                  // R2 sequential step
      case (ins[31:26])
        6'h00: begin                              // R3
          e.tag = 3; e.rf_we = 1'b1; e.waddr = ins[15:11];
          case (ins[5:0])
            6'h20: e.wdata = a + b;
            6'h22: e.wdata = a - b;
            6'h24: e.wdata = a & b;
            6'h25: e.wdata = a | b;
            6'h2A: e.wdata = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: begin e.rf_we = 1'b0; e.waddr = '0; e.tag = 10; end
          endcase
          if (ins[25:21] == 5'd0) e.tag = 9;      // R9 read of r0
        end
        6'h08: begin                              // R4
          e.tag = 4; e.rf_we = 1'b1; e.waddr = ins[20:16]; e.wdata = a + imm;
        end
        6'h23: begin                              // R5
          e.tag = 5; e.rf_we = 1'b1; e.waddr = ins[20:16];
          e.dm_re = 1'b1; e.daddr = a + imm; e.wdata = m[e.daddr[6:2]];
        end
        6'h2B: begin                              // R6
          e.tag = 6; e.dm_we = 1'b1; e.daddr = a + imm; e.dwdata = b;
        end
        6'h04: begin                              // R7
          e.tag = 7; pctag = 7;
          if (a == b) nx = pc + 32'd4 + {imm[29:0], 2'b00};
        end
        6'h02: begin                              // R8
          e.tag = 8; pctag = 8;
          nx = {nx[31:28], ins[25:0], 2'b00};
        end
        default: e.tag = 10;                      // R10
      endcase
      if (e.rf_we && e.waddr == 5'd0) e.tag = 9;
      if (k == 0) e.tag = 1;
      if (e.rf_we && e.waddr != 5'd0) r[e.waddr] = e.wdata;
      if (e.dm_we) m[e.daddr[6:2]] = e.dwdata;
      q.push_back(e);
      pc = nx;
    end
  endtask

  // Monitor: pops and compares once per cycle away from the active edge
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.pctag, "pc", pc_o, e.pc);
      chk(2, "instr", instr_o, PROG[e.pc[6:2]*32 +: 32]);
      chk(e.tag, "rf_we", {31'b0, rf_we_o}, {31'b0, e.rf_we});
      if (e.rf_we) begin
        chk(e.tag, "rf_waddr", {27'b0, rf_waddr_o}, {27'b0, e.waddr});
        chk(e.tag, "rf_wdata", rf_wdata_o, e.wdata);
      end
      chk(e.tag, "dm_we", {31'b0, dm_we_o}, {31'b0, e.dm_we});
      chk(e.tag, "dm_re", {31'b0, dm_re_o}, {31'b0, e.dm_re});
      if (e.dm_we) begin
        chk(e.tag, "dm_addr", dm_addr_o, e.daddr);
        chk(e.tag, "dm_wdata", dm_wdata_o, e.dwdata);
      end
      if (e.dm_re) begin
        chk(e.tag, "dm_addr", dm_addr_o, e.daddr);
        chk(e.tag, "dm_rdata", dm_rdata_o, e.wdata);
      end
    end
  end

  task automatic reset_check();
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(1, "reset pc", pc_o, 32'd0);                    // R1
    chk(1, "reset instr", instr_o, PROG[31:0]);         // R1
    @(posedge clk); #1 rst = 1'b0;
  endtask

  initial begin
    push_run(30);
    reset_check();
    wait (q.size() == 0);
    push_run(30);
    reset_check();
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule